// File: doc/BRIEF.md
# Four-Channel Single-Transfer DMA Controller

This block moves bytes between peripherals and memory on behalf of a CPU. Four channels are set up independently through an 8-bit register port. Each channel keeps a 16-bit current address, a 16-bit current count, base copies of both, and a mode byte. Software programs a channel and clears its mask bit. A peripheral then raises its request line. The controller asks the CPU for the bus with a hold request, waits for hold acknowledge, and then runs one transfer cycle. In that cycle it drives the channel acknowledge, the memory address and the matching memory and I/O strobes. It then releases the bus.

A transfer run ends when the count passes zero or when the end-of-process input is high during a transfer cycle. The terminal-count output is raised during that final cycle. After that the channel either masks itself or, with auto-initialisation, reloads its current address and count from the base copies and stays armed. In memory-to-memory mode a request on channel 0 starts a copy that holds the bus for the whole run. Each byte takes two cycles: a read at the channel 0 address into a holding register, then a write of that byte at the channel 1 address. The run ends with the channel 1 count.

Top module: `dma4_engine`

## Requirements
- R1: Register offsets 0 to 7 map to channel n's address (offset 2n) and count (offset 2n+1). Each is written and read as two bytes, low byte first. One shared byte pointer toggles on every such access. Any write to offset 11 resets the pointer to the low byte. A write sets both the base and the current value, and a read returns the current value.
- R2: After reset every channel is masked. A masked channel's request never produces a hold request. A write to offset 9 sets (data bit 2 = 1) or clears (bit 2 = 0) the mask of the channel in data bits 1:0.
- R3: An unmasked request makes hold_req rise on the next clock. No acknowledge or strobe appears until hold_ack is high. Exactly one transfer cycle with a one-hot acknowledge follows, and hold_req is low on the clock after it.
- R4: In single mode one byte moves per request. A request held high after its transfer is not served again until it has been low for at least one clock.
- R5: When several channels request at once, the lowest-numbered one is served first.
- R6: A write to offset 8 sets the mode of the channel in data bits 1:0. Data bits 3:2 select the direction. 01 writes to memory: mem_wr and io_rd are high. 10 reads from memory: mem_rd and io_wr are high. 00 is verify: no strobe is driven. Bit 4 enables auto-initialisation and bit 5 selects decrement.
- R7: The current address steps by one per transfer, up or down per the mode. It wraps within 16 bits (FFFFh to 0000h and back).
- R8: The count decrements once per transfer. tc_out is high during the transfer cycle in which the count was 0, so a programmed count N gives N+1 transfers, and the count then reads back FFFFh.
- R9: eop_in high during a transfer cycle ends the run exactly like an expired count, including tc_out.
- R10: When a run ends without auto-initialisation, the channel sets its mask bit. Every run end sets the channel's bit (bit n) in the status byte at offset 12, and reading offset 12 clears all such bits.
- R11: With auto-initialisation, the end of a run reloads the current address and count from the base values and leaves the channel unmasked.
- R12: With bit 0 of the command register (offset 10) set, a channel 0 request starts a copy. It alternates a mem_rd cycle at the channel 0 address and a mem_wr cycle at the channel 1 address carrying the byte just read. hold_req stays high throughout, and tc_out is high on the write in which the channel 1 count was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cs | input | 1 | Register port select |
| cpu_wr | input | 1 | One-cycle register write strobe |
| cpu_rd | input | 1 | One-cycle register read strobe |
| cpu_addr | input | 4 | Register offset |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data |
| dreq | input | 4 | Per-channel transfer requests |
| dack | output | 4 | Per-channel acknowledges, one-hot during a transfer cycle |
| hold_req | output | 1 | Bus request to the CPU |
| hold_ack | input | 1 | Bus grant from the CPU |
| eop_in | input | 1 | External end-of-process |
| tc_out | output | 1 | Terminal count, high in the final transfer cycle |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| mem_rdata | input | 8 | Memory read data for copies |
| mem_wdata | output | 8 | Memory write data for copies |

## Verification
The bench uses the default build: four channels, 16-bit addresses and 16-bit counts. With 16-bit fields, a start address of 0000h or FFFFh reaches both wrap directions in a single step, and small programmed counts reach the count roll-over in two or three transfers. Four channels allow requests from channels 1 and 3 to compete while channel 0 stays reserved for the copy source and for the external end-of-process run.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    // Transfer direction, taken from mode bits 3:2
    typedef enum logic [1:0] {
        DIR_VERIFY   = 2'b00,
        DIR_TO_MEM   = 2'b01,
        DIR_FROM_MEM = 2'b10,
        DIR_RSVD     = 2'b11
    } dir_e;

    // Packed so that it lines up with mode byte bits 5:2
    typedef struct packed {
        logic dec;
        logic auto_init;
        dir_e dir;
    } chmode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_XFER,
        ST_MRD,
        ST_MWR
    } seq_e;

endpackage

// File: rtl/dma4_prio.sv
module dma4_prio #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N-1:0] above;
    logic [N-1:0] gnt;

    assign above[0] = 1'b0;
    generate
        for (genvar i = 1; i < N; i++) begin : g_above
            assign above[i] = above[i-1] | req[i-1];
        end
    endgenerate

    assign gnt = req & ~above;
    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_addr,
    input  logic          ld_cnt,
    input  logic          ld_hi,
    input  logic [7:0]    ld_byte,
    input  logic          ld_mode,
    input  chmode_t       mode_in,
    input  logic          step,
    input  logic          reload,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_cnt,
    output chmode_t       mode,
    output logic          cnt_zero
);
    localparam int AHW = AW - 8;
    localparam int CHW = CW - 8;

    typedef struct packed {
        logic [AW-1:0] base_addr;
        logic [AW-1:0] cur_addr;
        logic [CW-1:0] base_cnt;
        logic [CW-1:0] cur_cnt;
        chmode_t       mode;
    } chan_t;

    chan_t q, d;

    always_comb begin
        d = q;
        if (ld_addr) begin
            if (ld_hi) begin
                d.base_addr[AW-1:8] = AHW'(ld_byte);
                d.cur_addr[AW-1:8]  = AHW'(ld_byte);
            end else begin
                d.base_addr[7:0] = ld_byte;
                d.cur_addr[7:0]  = ld_byte;
            end
        end
        if (ld_cnt) begin
            if (ld_hi) begin
                d.base_cnt[CW-1:8] = CHW'(ld_byte);
                d.cur_cnt[CW-1:8]  = CHW'(ld_byte);
            end else begin
                d.base_cnt[7:0] = ld_byte;
                d.cur_cnt[7:0]  = ld_byte;
            end
        end
        if (ld_mode) d.mode = mode_in;
        if (reload) begin
            d.cur_addr = q.base_addr;
            d.cur_cnt  = q.base_cnt;
        end else if (step) begin
            d.cur_addr = q.mode.dec ? q.cur_addr - 1'b1 : q.cur_addr + 1'b1;
            d.cur_cnt  = q.cur_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_addr = q.cur_addr;
    assign cur_cnt  = q.cur_cnt;
    assign mode     = q.mode;
    assign cnt_zero = (q.cur_cnt == '0);
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RA_W = $clog2(2 * NCH + 5)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_cs,
    input  logic            cpu_wr,
    input  logic            cpu_rd,
    input  logic [RA_W-1:0] cpu_addr,
    input  logic [7:0]      cpu_wdata,
    output logic [7:0]      cpu_rdata,
    input  logic [NCH-1:0]  dreq,
    output logic [NCH-1:0]  dack,
    output logic            hold_req,
    input  logic            hold_ack,
    input  logic            eop_in,
    output logic            tc_out,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            io_rd,
    output logic            io_wr,
    input  logic [7:0]      mem_rdata,
    output logic [7:0]      mem_wdata
);
    localparam logic [RA_W-1:0] REG_MODE  = RA_W'(2 * NCH);
    localparam logic [RA_W-1:0] REG_MASK  = RA_W'(2 * NCH + 1);
    localparam logic [RA_W-1:0] REG_CMD   = RA_W'(2 * NCH + 2);
    localparam logic [RA_W-1:0] REG_CLRFF = RA_W'(2 * NCH + 3);
    localparam logic [RA_W-1:0] REG_STAT  = RA_W'(2 * NCH + 4);
    localparam int DW = (AW > CW) ? AW : CW;

    typedef struct packed {
        seq_e            st;
        logic [CH_W-1:0] ch;
        logic            ptr_hi;
        logic [NCH-1:0]  mask;
        logic [NCH-1:0]  tc_sts;
        logic [NCH-1:0]  served;
        logic            m2m;
        logic [7:0]      temp;
    } ctl_t;

    ctl_t q, d;

    logic [AW-1:0]   c_addr [NCH];
    logic [CW-1:0]   c_cnt  [NCH];
    chmode_t         c_mode [NCH];
    logic [NCH-1:0]  c_zero;
    logic [NCH-1:0]  ld_addr, ld_cnt, ld_mode, step, reload;
    chmode_t         mode_wr;
    logic [NCH-1:0]  eligible;
    logic            win_any;
    logic [CH_W-1:0] win_idx;
    logic            cpu_we, cpu_re, chan_hit, is_cnt;
    logic [CH_W-1:0] sel;
    logic [DW-1:0]   rd_word;
    logic            end_now;

    assign cpu_we   = cpu_cs & cpu_wr;
    assign cpu_re   = cpu_cs & cpu_rd;
    assign chan_hit = cpu_addr < REG_MODE;
    assign is_cnt   = cpu_addr[0];
    assign sel      = cpu_addr[CH_W:1];
    assign mode_wr  = chmode_t'(cpu_wdata[5:2]);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chan
            dma4_chan #(.AW(AW), .CW(CW)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .ld_addr  (ld_addr[i]),
                .ld_cnt   (ld_cnt[i]),
                .ld_hi    (q.ptr_hi),
                .ld_byte  (cpu_wdata),
                .ld_mode  (ld_mode[i]),
                .mode_in  (mode_wr),
                .step     (step[i]),
                .reload   (reload[i]),
                .cur_addr (c_addr[i]),
                .cur_cnt  (c_cnt[i]),
                .mode     (c_mode[i]),
                .cnt_zero (c_zero[i])
            );
        end
    endgenerate

    // Channel 1 is the copy destination while memory-to-memory is on
    always_comb begin
        eligible = dreq & ~q.mask & ~q.served;
        if (q.m2m) eligible[1] = 1'b0;
    end

    dma4_prio #(.N(NCH)) u_prio (
        .req (eligible),
        .any (win_any),
        .idx (win_idx)
    );

    always_comb begin
        d       = q;
        ld_addr = '0;
        ld_cnt  = '0;
        ld_mode = '0;
        step    = '0;
        reload  = '0;
        end_now = 1'b0;
        d.served = q.served & dreq;

        // register port
        if ((cpu_we || cpu_re) && chan_hit) d.ptr_hi = ~q.ptr_hi;
        if (cpu_we && chan_hit) begin
            if (is_cnt) ld_cnt[sel]  = 1'b1;
            else        ld_addr[sel] = 1'b1;
        end
        if (cpu_we && cpu_addr == REG_MODE)  ld_mode[cpu_wdata[CH_W-1:0]] = 1'b1;
        if (cpu_we && cpu_addr == REG_MASK)  d.mask[cpu_wdata[CH_W-1:0]] = cpu_wdata[2];
        if (cpu_we && cpu_addr == REG_CMD)   d.m2m = cpu_wdata[0];
        if (cpu_we && cpu_addr == REG_CLRFF) d.ptr_hi = 1'b0;
        if (cpu_re && cpu_addr == REG_STAT)  d.tc_sts = '0;

        // transfer sequencing
        case (q.st)
            ST_IDLE: begin
                if (win_any) begin
                    d.ch = win_idx;
                    d.st = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (hold_ack) d.st = (q.m2m && q.ch == '0) ? ST_MRD : ST_XFER;
            end
            ST_XFER: begin
                end_now = c_zero[q.ch] | eop_in;
                step[q.ch] = 1'b1;
                d.served[q.ch] = 1'b1;
                if (end_now) begin
                    if (c_mode[q.ch].auto_init) reload[q.ch] = 1'b1;
                    else                        d.mask[q.ch] = 1'b1;
                    d.tc_sts[q.ch] = 1'b1;
                end
                d.st = ST_IDLE;
            end
            ST_MRD: begin
                d.temp = mem_rdata;
                d.st   = ST_MWR;
            end
            ST_MWR: begin
                end_now = c_zero[1] | eop_in;
                step[0] = 1'b1;
                step[1] = 1'b1;
                if (end_now) begin
                    for (int k = 0; k < 2; k++) begin
                        if (c_mode[k].auto_init) reload[k] = 1'b1;
                        else                     d.mask[k] = 1'b1;
                        d.tc_sts[k] = 1'b1;
                    end
                    d.served[0] = 1'b1;
                    d.st = ST_IDLE;
                end else begin
                    d.st = ST_MRD;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mask <= '1;
        end else begin
            q <= d;
        end
    end

    // bus side outputs
    always_comb begin
        dack     = '0;
        mem_addr = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        tc_out   = 1'b0;
        case (q.st)
            ST_XFER: begin
                dack     = NCH'(1) << q.ch;
                mem_addr = c_addr[q.ch];
                mem_wr   = (c_mode[q.ch].dir == DIR_TO_MEM);
                io_rd    = (c_mode[q.ch].dir == DIR_TO_MEM);
                mem_rd   = (c_mode[q.ch].dir == DIR_FROM_MEM);
                io_wr    = (c_mode[q.ch].dir == DIR_FROM_MEM);
                tc_out   = c_zero[q.ch] | eop_in;
            end
            ST_MRD: begin
                mem_addr = c_addr[0];
                mem_rd   = 1'b1;
            end
            ST_MWR: begin
                mem_addr = c_addr[1];
                mem_wr   = 1'b1;
                tc_out   = c_zero[1] | eop_in;
            end
            default: ;
        endcase
    end

    assign hold_req  = (q.st != ST_IDLE);
    assign mem_wdata = q.temp;

    // register read-back
    always_comb begin
        rd_word   = is_cnt ? DW'(c_cnt[sel]) : DW'(c_addr[sel]);
        cpu_rdata = '0;
        if (chan_hit)                 cpu_rdata = q.ptr_hi ? 8'(rd_word >> 8) : rd_word[7:0];
        else if (cpu_addr == REG_STAT) cpu_rdata[NCH-1:0] = q.tc_sts;
    end
endmodule

// File: rtl/dma4_engine_chk.sv
module dma4_engine_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hold_req,
    input logic           hold_ack,
    input logic [NCH-1:0] dack,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           io_rd,
    input logic           io_wr,
    input logic           tc_out
);
    // R3: acknowledge only while the bus is granted
    a_r3_dack_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |-> (hold_ack && hold_req));

    // R3: at most one channel acknowledged
    a_r3_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    // R3, R4: bus released right after a single transfer
    a_r4_one_byte_then_release: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |=> (!hold_req && dack == '0));

    // R6: opposing strobes never together
    a_r6_mem_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r6_io_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr));

    // R8: terminal count only in a transfer cycle
    a_r8_tc_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        tc_out |-> ((|dack) || mem_wr));

    // R12: a copy read is always followed by its write
    a_r12_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && dack == '0) |=> mem_wr);
endmodule

bind dma4_engine dma4_engine_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_req (hold_req),
    .hold_ack (hold_ack),
    .dack     (dack),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .tc_out   (tc_out)
);

// File: tb/dma4_engine_tb.sv
module dma4_engine_tb;
    localparam logic [3:0] A_MODE = 4'd8;
    localparam logic [3:0] A_MASK = 4'd9;
    localparam logic [3:0] A_CMD  = 4'd10;
    localparam logic [3:0] A_CLR  = 4'd11;
    localparam logic [3:0] A_STAT = 4'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_cs = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic        hold_req;
    logic        hold_ack = 1'b0;
    logic        eop_in = 1'b0;
    logic        tc_out;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  mem_wdata;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] s_addr;
    logic [3:0]  s_dack;
    logic        s_mrd, s_mwr, s_ird, s_iwr, s_tc;

    always #2 clk = ~clk;

    dma4_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dreq(dreq), .dack(dack), .hold_req(hold_req), .hold_ack(hold_ack),
        .eop_in(eop_in), .tc_out(tc_out), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        cpu_cs = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = v;
        @(negedge clk);
        cpu_cs = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        cpu_cs = 1'b1; cpu_rd = 1'b1; cpu_addr = a;
        #1 v = cpu_rdata;
        @(negedge clk);
        cpu_cs = 1'b0; cpu_rd = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] v);
        cpu_write(A_CLR, 8'h00);
        cpu_write(a, v[7:0]);
        cpu_write(a, v[15:8]);
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        cpu_write(A_CLR, 8'h00);
        cpu_read(a, lo);
        cpu_read(a, hi);
        v = {hi, lo};
    endtask

    function automatic logic [7:0] md(input int ch, input bit dec, input bit au, input logic [1:0] dir);
        return {2'b00, dec, au, dir, 2'(ch)};
    endfunction

    task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] c, input logic [7:0] m);
        wr16(4'(2 * ch), a);
        wr16(4'(2 * ch + 1), c);
        cpu_write(A_MODE, m);
        cpu_write(A_MASK, {5'b0, 1'b0, 2'(ch)});
    endtask

    // one single-mode transfer on channel ch, results in s_*
    task automatic serve(input int ch, input bit eop, input bit keep);
        int n;
        @(negedge clk);
        dreq[ch] = 1'b1;
        n = 0;
        while (!hold_req && n < 20) begin @(negedge clk); n++; end
        chk("R3 hold_req raised", 32'(hold_req), 32'd1);
        chk("R3 no dack before grant", 32'(dack), 32'd0);
        hold_ack = 1'b1;
        eop_in = eop;
        n = 0;
        @(negedge clk);
        while (dack == '0 && n < 20) begin @(negedge clk); n++; end
        s_addr = mem_addr; s_dack = dack; s_mrd = mem_rd; s_mwr = mem_wr;
        s_ird = io_rd; s_iwr = io_wr; s_tc = tc_out;
        chk("R3 one-hot dack", 32'(s_dack), 32'(4'b1 << ch));
        @(negedge clk);
        chk("R3 hold_req released", 32'(hold_req), 32'd0);
        hold_ack = 1'b0;
        eop_in = 1'b0;
        if (!keep) dreq[ch] = 1'b0;
    endtask

    task automatic no_hold(input int ch, input string tag);
        @(negedge clk);
        dreq[ch] = 1'b1;
        repeat (6) @(negedge clk);
        chk(tag, 32'(hold_req), 32'd0);
        dreq[ch] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R2 reset hold_req", 32'(hold_req), 32'd0);
        chk("R2 reset dack", 32'(dack), 32'd0);
        chk("R8 reset tc_out", 32'(tc_out), 32'd0);
        cpu_read(A_STAT, v);
        chk("R10 reset status", 32'(v), 32'd0);
        no_hold(0, "R2 masked after reset");
    endtask

    task automatic t_regs;
        logic [15:0] v;
        wr16(4'd4, 16'hBEEF);
        rd16(4'd4, v);
        chk("R1 address readback", 32'(v), 32'hBEEF);
        cpu_write(A_CLR, 8'h00);
        cpu_write(4'd5, 8'h11);
        cpu_write(A_CLR, 8'h00);
        cpu_write(4'd5, 8'h22);
        cpu_write(4'd5, 8'h33);
        rd16(4'd5, v);
        chk("R1 pointer clear", 32'(v), 32'h3322);
    endtask

    task automatic t_single_inc;
        logic [7:0] st;
        logic [15:0] v;
        prog(2, 16'h1234, 16'd2, md(2, 0, 0, 2'b01));
        for (int k = 0; k < 3; k++) begin
            serve(2, 0, 0);
            chk("R7 increment address", 32'(s_addr), 32'(16'h1234 + k));
            chk("R6 to-memory strobes", {28'b0, s_mrd, s_mwr, s_ird, s_iwr}, 32'b0110);
            chk("R8 tc on final", 32'(s_tc), 32'(k == 2));
        end
        rd16(4'd5, v);
        chk("R8 count rolled", 32'(v), 32'hFFFF);
        cpu_read(A_STAT, st);
        chk("R10 status bit", 32'(st), 32'h04);
        cpu_read(A_STAT, st);
        chk("R10 status cleared by read", 32'(st), 32'h00);
        no_hold(2, "R10 masked at end");
    endtask

    task automatic t_rerequest;
        prog(0, 16'h0040, 16'd5, md(0, 0, 0, 2'b01));
        serve(0, 0, 1);
        chk("R4 first byte", 32'(s_addr), 32'h0040);
        repeat (5) @(negedge clk);
        chk("R4 held request not reserved", 32'(hold_req), 32'd0);
        dreq[0] = 1'b0;
        @(negedge clk);
        serve(0, 0, 0);
        chk("R4 second request served", 32'(s_addr), 32'h0041);
    endtask

    task automatic t_prio;
        int n;
        prog(1, 16'h0500, 16'd9, md(1, 0, 0, 2'b01));
        prog(3, 16'h0700, 16'd9, md(3, 0, 0, 2'b01));
        @(negedge clk);
        dreq[1] = 1'b1; dreq[3] = 1'b1;
        n = 0;
        while (!hold_req && n < 20) begin @(negedge clk); n++; end
        hold_ack = 1'b1;
        @(negedge clk);
        chk("R5 lowest channel first", 32'(dack), 32'b0010);
        chk("R5 first address", 32'(mem_addr), 32'h0500);
        @(negedge clk);
        hold_ack = 1'b0; dreq[1] = 1'b0;
        n = 0;
        while (!hold_req && n < 20) begin @(negedge clk); n++; end
        hold_ack = 1'b1;
        @(negedge clk);
        chk("R5 next channel", 32'(dack), 32'b1000);
        chk("R5 next address", 32'(mem_addr), 32'h0700);
        @(negedge clk);
        hold_ack = 1'b0; dreq[3] = 1'b0;
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        prog(3, 16'h0000, 16'd9, md(3, 1, 0, 2'b10));
        serve(3, 0, 0);
        chk("R7 decrement start", 32'(s_addr), 32'h0000);
        chk("R6 from-memory strobes", {28'b0, s_mrd, s_mwr, s_ird, s_iwr}, 32'b1001);
        serve(3, 0, 0);
        chk("R7 wrap down", 32'(s_addr), 32'hFFFF);
        rd16(4'd6, v);
        chk("R7 current after decrement", 32'(v), 32'hFFFE);
        prog(1, 16'hFFFF, 16'd9, md(1, 0, 0, 2'b00));
        serve(1, 0, 0);
        chk("R6 verify no strobes", {28'b0, s_mrd, s_mwr, s_ird, s_iwr}, 32'b0000);
        rd16(4'd2, v);
        chk("R7 wrap up", 32'(v), 32'h0000);
    endtask

    task automatic t_auto;
        logic [15:0] v;
        prog(1, 16'h0100, 16'd1, md(1, 0, 1, 2'b01));
        serve(1, 0, 0);
        chk("R11 first no tc", 32'(s_tc), 32'd0);
        serve(1, 0, 0);
        chk("R11 second tc", 32'(s_tc), 32'd1);
        rd16(4'd2, v);
        chk("R11 address reloaded", 32'(v), 32'h0100);
        rd16(4'd3, v);
        chk("R11 count reloaded", 32'(v), 32'h0001);
        serve(1, 0, 0);
        chk("R11 still armed", 32'(s_addr), 32'h0100);
    endtask

    task automatic t_eop;
        logic [7:0] st;
        cpu_read(A_STAT, st);
        prog(0, 16'h0A00, 16'h0010, md(0, 0, 0, 2'b01));
        serve(0, 1, 0);
        chk("R9 external end raises tc", 32'(s_tc), 32'd1);
        cpu_read(A_STAT, st);
        chk("R9 status after external end", 32'(st), 32'h01);
        no_hold(0, "R9 masked after external end");
    endtask

    task automatic t_m2m;
        int n, k;
        bit early_drop;
        prog(0, 16'h2000, 16'h00FF, md(0, 0, 0, 2'b10));
        prog(1, 16'h3000, 16'd2, md(1, 0, 0, 2'b01));
        cpu_write(A_CMD, 8'h01);
        @(negedge clk);
        dreq[0] = 1'b1;
        n = 0;
        while (!hold_req && n < 20) begin @(negedge clk); n++; end
        hold_ack = 1'b1;
        k = 0;
        early_drop = 1'b0;
        n = 0;
        while (k < 3 && n < 40) begin
            @(negedge clk);
            n++;
            if (!hold_req) early_drop = 1'b1;
            if (mem_rd) begin
                chk("R12 source address", 32'(mem_addr), 32'(16'h2000 + k));
                mem_rdata = mem_addr[7:0] ^ 8'hA5;
            end else if (mem_wr) begin
                chk("R12 destination address", 32'(mem_addr), 32'(16'h3000 + k));
                chk("R12 copied byte", 32'(mem_wdata), 32'(8'(k) ^ 8'hA5));
                chk("R12 tc on last write", 32'(tc_out), 32'(k == 2));
                k++;
            end
        end
        chk("R12 byte count", 32'(k), 32'd3);
        chk("R12 bus held through copy", 32'(early_drop), 32'd0);
        @(negedge clk);
        chk("R12 bus released", 32'(hold_req), 32'd0);
        hold_ack = 1'b0;
        dreq[0] = 1'b0;
        cpu_write(A_CMD, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_single_inc();
        t_rerequest();
        t_prio();
        t_wrap();
        t_auto();
        t_eop();
        t_m2m();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule